// File: doc/BRIEF.md
# Serial Register Port with Write Lock

This block is a four-wire serial slave that lets a host reach a bank of 64 addressed 24-bit registers. Every exchange is a fixed 32-bit frame: a command byte, most significant bit first, whose top two bits choose the operation and whose low six bits choose the address, followed by 24 data bits. The host clocks the frame. Bits from the host are taken on rising serial clock edges, and the reply also changes on rising edges.

The address space has several kinds of register:
- Measurement words: read-only, fed from parallel inputs.
- Calibration registers: stored, and writable only while a lock register holds the unlock key.
- Modular checksum: the sum of all calibration registers.
- Two echo registers: copies of the data of the last completed read and the last completed write, for host-side redundancy checks.

All serial inputs are brought into the system clock domain by two-flop synchronisers, and clock edges are found there. The system clock must run at least 8 times faster than the serial clock.

Address map (defaults):
- 0x00-0x0F: measurement inputs.
- 0x10-0x37: calibration registers.
- 0x38: checksum.
- 0x39: last-read echo.
- 0x3A: last-write echo.
- 0x3B: lock register.
- 0x3C-0x3F: unused.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is 8 command bits then 24 data bits, MSB first. Command bits [7:6]=00 read and 01 write; bits [5:0] are the address. On a read, `miso` shows data bits 23 down to 0 after serial edges 9 to 32. Registers narrower than 24 bits read with zeros at the top.
- R2: `miso` changes only in response to rising serial edges. It is 0 during the command byte, on all non-read frames, and while `cs_n` is high.
- R3: If `cs_n` rises before the 32nd rising edge, the frame is aborted. No register, echo or checksum changes, and the next frame is framed afresh.
- R4: The lock register resets to 00h. While it does not hold 55h, writes to calibration registers (0x10-0x37) are discarded.
- R5: The lock register (0x3B, 8 bits, stored from data bits [7:0]) accepts every write whatever its state. 55h unlocks; any other value locks again.
- R6: The last-write echo (0x3A) takes the 24 data bits of every completed write frame, including writes that were discarded.
- R7: The last-read echo (0x39) takes the data returned by every completed read frame.
- R8: The checksum (0x38) equals the sum, modulo 2^24, of all calibration registers. It updates with each accepted calibration write.
- R9: Commands with bits [7:6] equal to 10 or 11 drive `miso` to 0 and change no register, echo included.
- R10: Writes to measurement, checksum and echo addresses have no effect. Addresses 0x3C-0x3F read as 0.
- R11: A read of address n (0x00-0x0F) returns the current value of measurement input n.
- R12: After reset, all calibration registers, the checksum, both echoes and the lock register are 0, and `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| meas_flat | input | MEAS_CNT*24 | Measurement words, word n at bits [24n+23:24n] |
| miso | output | 1 | Serial data to host, registered |

## Verification
The bench goes after four corner cases:
- Locking. A lock that was not enforced would let a write land while locked. A lock value compared wrongly would refuse a write after unlock.
- Aborted frames. A counter that is not cleared on `cs_n` high would commit data that arrived in two pieces.
- Checksum. A checksum that adds without subtracting the old value drifts after an overwrite; the wrap case shows a missing carry drop.
- Reserved commands and read-only addresses. Either one would show up as changed echoes or changed data.

Data that is off by one serial edge appears as every read word shifted by one bit.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int DW = 24;
  localparam int AW = 6;
  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_RSA = 2'b10,
    OP_RSB = 2'b11
  } op_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= RST_VAL;
      dout  <= RST_VAL;
      dprev <= RST_VAL;
    end else begin
      s1    <= din;
      dout  <= s1;
      dprev <= dout;
    end
  end
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW,
  localparam int FRAME_BITS = CMD_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_rise,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso,
  output logic              cmd_stb,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              done_stb,
  output logic [DATA_W-1:0] done_data,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] tx_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] rx_next;

  assign rx_next  = {rx_q[DATA_W-2:0], mosi_s};
  assign cmd_op   = op_e'(cmd_q[7:6]);
  assign cmd_addr = cmd_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      cmd_q     <= '0;
      miso      <= 1'b0;
      cmd_stb   <= 1'b0;
      done_stb  <= 1'b0;
      done_data <= '0;
    end else if (cs_n_s) begin
      bit_cnt  <= '0;
      tx_q     <= '0;
      miso     <= 1'b0;
      cmd_stb  <= 1'b0;
      done_stb <= 1'b0;
    end else begin
      cmd_stb  <= 1'b0;
      done_stb <= 1'b0;
      if (cmd_stb)
        tx_q <= (cmd_op == OP_RD) ? rd_data : '0;
      if (sclk_rise && (bit_cnt < CNT_W'(FRAME_BITS))) begin
        bit_cnt <= bit_cnt + 1'b1;
        rx_q    <= rx_next;
        if (bit_cnt == CNT_W'(CMD_W - 1)) begin
          cmd_q   <= rx_next[CMD_W-1:0];
          cmd_stb <= 1'b1;
        end
        if (bit_cnt >= CNT_W'(CMD_W)) begin
          miso <= tx_q[DATA_W-1];
          tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
        if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
          done_stb  <= 1'b1;
          done_data <= rx_next;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rb_bank.sv
module spi_rb_bank
  import spi_rb_pkg::*;
#(
  parameter int DATA_W    = DW,
  parameter int ADDR_W    = AW,
  parameter int MEAS_CNT  = 16,
  parameter int CAL_BASE  = 16,
  parameter int CAL_CNT   = 40,
  parameter int A_CSUM    = 56,
  parameter int A_ECHO_RD = 57,
  parameter int A_ECHO_WR = 58,
  parameter int A_KEY     = 59,
  parameter int KEY_W     = 8,
  parameter logic [KEY_W-1:0] KEY_OPEN = 8'h55,
  localparam int CIW = (CAL_CNT > 1) ? $clog2(CAL_CNT) : 1,
  localparam int MIW = (MEAS_CNT > 1) ? $clog2(MEAS_CNT) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [MEAS_CNT*DATA_W-1:0] meas_flat,
  input  logic [ADDR_W-1:0]          addr,
  input  op_e                        op,
  input  logic                       cmd_stb,
  input  logic                       done_stb,
  input  logic [DATA_W-1:0]          done_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic [DATA_W-1:0]          csum_q,
  output logic [DATA_W-1:0]          echo_wr_q,
  output logic [KEY_W-1:0]           key_q
);
  logic [DATA_W-1:0] meas_w [MEAS_CNT];
  logic [DATA_W-1:0] cal_q  [CAL_CNT];
  logic [DATA_W-1:0] echo_rd_q;
  logic [DATA_W-1:0] rd_hold;
  logic [ADDR_W-1:0] cal_off;
  logic [CIW-1:0]    cal_idx;
  logic              is_cal;
  logic              is_meas;

  for (genvar g = 0; g < MEAS_CNT; g++) begin : g_meas
    assign meas_w[g] = meas_flat[g*DATA_W +: DATA_W];
  end

  assign is_meas = int'(addr) < MEAS_CNT;
  assign is_cal  = (int'(addr) >= CAL_BASE) && (int'(addr) < CAL_BASE + CAL_CNT);
  assign cal_off = addr - ADDR_W'(CAL_BASE);
  assign cal_idx = cal_off[CIW-1:0];

  always_comb begin
    rd_data = '0;
    if (is_meas)
      rd_data = meas_w[addr[MIW-1:0]];
    else if (is_cal)
      rd_data = cal_q[cal_idx];
    else if (int'(addr) == A_CSUM)
      rd_data = csum_q;
    else if (int'(addr) == A_ECHO_RD)
      rd_data = echo_rd_q;
    else if (int'(addr) == A_ECHO_WR)
      rd_data = echo_wr_q;
    else if (int'(addr) == A_KEY)
      rd_data = {{(DATA_W-KEY_W){1'b0}}, key_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CAL_CNT; i++) cal_q[i] <= '0;
      csum_q    <= '0;
      echo_rd_q <= '0;
      echo_wr_q <= '0;
      key_q     <= '0;
      rd_hold   <= '0;
    end else begin
      if (cmd_stb)
        rd_hold <= rd_data;
      if (done_stb && op == OP_RD)
        echo_rd_q <= rd_hold;
      if (done_stb && op == OP_WR) begin
        echo_wr_q <= done_data;
        if (int'(addr) == A_KEY)
          key_q <= done_data[KEY_W-1:0];
        if (is_cal && key_q == KEY_OPEN) begin
          cal_q[cal_idx] <= done_data;
          csum_q <= csum_q - cal_q[cal_idx] + done_data;
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_rb_pkg::*;
#(
  parameter int MEAS_CNT = 16,
  parameter int CAL_BASE = 16,
  parameter int CAL_CNT  = 40,
  parameter int KEY_W    = 8,
  localparam int FRAME_BITS = CMD_W + DW,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   mosi,
  input  logic [MEAS_CNT*DW-1:0] meas_flat,
  output logic                   miso
);
  logic [2:0]       pin_s, pin_d;
  logic             sclk_rise;
  logic             cmd_stb, done_stb;
  op_e              cmd_op;
  logic [AW-1:0]    cmd_addr;
  logic [DW-1:0]    done_data, rd_data, csum_q, echo_wr_q;
  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] bit_cnt;

  spi_rb_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .din({cs_n, sclk, mosi}),
    .dout(pin_s), .dprev(pin_d)
  );

  assign sclk_rise = pin_s[1] & ~pin_d[1];

  spi_rb_frame #(.DATA_W(DW), .ADDR_W(AW)) u_frame (
    .clk(clk), .rst(rst), .cs_n_s(pin_s[2]), .sclk_rise(sclk_rise),
    .mosi_s(pin_s[0]), .rd_data(rd_data), .miso(miso),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .done_stb(done_stb), .done_data(done_data), .bit_cnt(bit_cnt)
  );

  spi_rb_bank #(
    .DATA_W(DW), .ADDR_W(AW), .MEAS_CNT(MEAS_CNT), .CAL_BASE(CAL_BASE),
    .CAL_CNT(CAL_CNT), .A_CSUM(CAL_BASE + CAL_CNT), .A_ECHO_RD(CAL_BASE + CAL_CNT + 1),
    .A_ECHO_WR(CAL_BASE + CAL_CNT + 2), .A_KEY(CAL_BASE + CAL_CNT + 3),
    .KEY_W(KEY_W), .KEY_OPEN(KEY_W'(8'h55))
  ) u_bank (
    .clk(clk), .rst(rst), .meas_flat(meas_flat), .addr(cmd_addr), .op(cmd_op),
    .cmd_stb(cmd_stb), .done_stb(done_stb), .done_data(done_data),
    .rd_data(rd_data), .csum_q(csum_q), .echo_wr_q(echo_wr_q), .key_q(key_q)
  );
endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker #(
  parameter int CAL_BASE = 16,
  parameter int CAL_CNT  = 40,
  parameter int KEY_W    = 8,
  parameter int CNT_W    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             miso,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             cmd_stb,
  input logic             done_stb,
  input logic [1:0]       op,
  input logic [5:0]       addr,
  input logic [23:0]      done_data,
  input logic [23:0]      csum_q,
  input logic [23:0]      echo_wr_q,
  input logic [KEY_W-1:0] key_q
);
  logic wr_cal;
  assign wr_cal = done_stb && op == 2'b01 &&
                  int'(addr) >= CAL_BASE && int'(addr) < CAL_BASE + CAL_CNT;

  // R2: DOUT idles low once select has been high long enough to pass the synchroniser
  a_r2_miso_idle: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n,2) && $past(cs_n,3) && $past(cs_n,4)) |-> !miso);

  // R3: no frame completes while select is held high
  a_r3_no_done_idle: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n,2) && $past(cs_n,3)) |-> !done_stb);

  // R3: the bit counter never runs past one frame
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(32));

  // R1: command decode and frame end never coincide
  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_stb, done_stb}));

  // R4: a locked calibration write leaves the checksum alone
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_cal && key_q != KEY_W'(8'h55)) |=> $stable(csum_q));

  // R8: the checksum moves only on a calibration write
  a_r8_csum_quiet: assert property (@(posedge clk) disable iff (rst)
    !wr_cal |=> $stable(csum_q));

  // R9: reserved commands touch neither the write echo nor the lock
  a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (done_stb && op[1]) |=> ($stable(echo_wr_q) && $stable(key_q)));

  // R6: the write echo changes only at the end of a write frame
  a_r6_echo_only_on_wr: assert property (@(posedge clk) disable iff (rst)
    !(done_stb && op == 2'b01) |=> $stable(echo_wr_q));
endmodule

bind spi_reg_slave spi_rb_checker #(
  .CAL_BASE(CAL_BASE), .CAL_CNT(CAL_CNT), .KEY_W(KEY_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .miso(miso), .bit_cnt(bit_cnt),
  .cmd_stb(cmd_stb), .done_stb(done_stb), .op(cmd_op), .addr(cmd_addr),
  .done_data(done_data), .csum_q(csum_q), .echo_wr_q(echo_wr_q), .key_q(key_q)
);

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;
  localparam int MEAS_CNT = 16;
  localparam int HALF = 32;
  localparam int GAP  = 80;
  localparam int NV   = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [MEAS_CNT*24-1:0] meas_flat;
  logic miso;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .meas_flat(meas_flat), .miso(miso)
  );

  function automatic logic [23:0] meas_val(input int i);
    return 24'h0A0000 + 24'(i) * 24'h000111;
  endfunction

  // {command, write data, expected reply}
  localparam logic [55:0] VEC [NV] = '{
    56'h03_000000_0A0333, 56'h50_123456_000000, 56'h10_000000_000000,
    56'h3A_000000_123456, 56'h7B_000055_000000, 56'h3B_000000_000055,
    56'h50_123456_000000, 56'h10_000000_123456, 56'h77_00F00F_000000,
    56'h38_000000_132465, 56'h50_000001_000000, 56'h38_000000_00F010,
    56'h39_000000_00F010, 56'h90_FFFFFF_000000, 56'h10_000000_000001,
    56'h3A_000000_000001, 56'hD0_000000_000000, 56'h39_000000_000001,
    56'h7B_0000AA_000000, 56'h50_777777_000000, 56'h10_000000_000001,
    56'h3B_000000_0000AA, 56'h43_000001_000000, 56'h03_000000_0A0333,
    56'h78_000000_000000, 56'h38_000000_00F010, 56'h3E_000000_000000,
    56'h7B_000055_000000, 56'h51_FFFFFF_000000, 56'h38_000000_00F00F,
    56'h11_000000_FFFFFF
  };
  localparam string TAG [NV] = '{
    "R11", "R4", "R4", "R6", "R5", "R5", "R5", "R5", "R8", "R8", "R8",
    "R8", "R7", "R9", "R9", "R9", "R9", "R9", "R5", "R5", "R5", "R5",
    "R10", "R10", "R10", "R10", "R10", "R5", "R8", "R8", "R1"
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [23:0] wd, input int nbits,
                      output logic [23:0] rd, output logic cmd_hi);
    logic [31:0] f;
    f = {cmd, wd};
    rd = '0;
    cmd_hi = 1'b0;
    cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = f[31-i];
      #(HALF);
      sclk = 1'b1;
      #(HALF);
      sclk = 1'b0;
      if (i >= 8) rd = {rd[22:0], miso};
      else cmd_hi = cmd_hi | miso;
    end
    #(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    #(GAP);
  endtask

  initial begin
    logic [23:0] rd;
    logic hi;
    for (int i = 0; i < MEAS_CNT; i++) meas_flat[i*24 +: 24] = meas_val(i);
    #1;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    #(GAP);
    // R12 reset state
    chk("R12 miso", {23'b0, miso}, 24'h0);
    xfer(8'h3B, 24'h0, 32, rd, hi); chk("R12 lock", rd, 24'h0);
    xfer(8'h38, 24'h0, 32, rd, hi); chk("R12 csum", rd, 24'h0);
    xfer(8'h3A, 24'h0, 32, rd, hi); chk("R12 echo", rd, 24'h0);

    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][55:48], VEC[v][47:24], 32, rd, hi);
      chk($sformatf("%s vec%0d", TAG[v], v), rd, VEC[v][23:0]);
      chk($sformatf("R2 cmd-phase low vec%0d", v), {23'b0, hi}, 24'h0);
    end

    // R3: aborted write after 20 bits, lock currently open
    xfer(8'h50, 24'hABCDEF, 20, rd, hi);
    xfer(8'h10, 24'h0, 32, rd, hi); chk("R3 data kept", rd, 24'h000001);
    xfer(8'h3A, 24'h0, 32, rd, hi); chk("R3 echo kept", rd, 24'hFFFFFF);
    xfer(8'h38, 24'h0, 32, rd, hi); chk("R3 csum kept", rd, 24'h00F00F);
    xfer(8'h50, 24'h000002, 32, rd, hi);
    xfer(8'h10, 24'h0, 32, rd, hi); chk("R3 recovery", rd, 24'h000002);

    // R11: measurement inputs are read live
    meas_flat[5*24 +: 24] = 24'hC0FFEE;
    xfer(8'h05, 24'h0, 32, rd, hi); chk("R11 live", rd, 24'hC0FFEE);
    // R2: idle output after frames
    chk("R2 idle", {23'b0, miso}, 24'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule